// File: doc/BRIEF.md
# I2C Block Transfer Controller

This controller sits between a requester and a byte-level two-wire bus engine. It turns one block request into the whole series of engine commands that the transfer needs. A request names a 7-bit device, a one-byte register offset, a byte count and a direction. The engine does the bit timing: generating START and STOP conditions, shifting one byte, sampling the acknowledge bit, and waiting out the bus-free gap. Write bytes arrive and read bytes leave through plain valid/ready byte ports.

Reads address the device, send the offset, wait for the bus-free gap, and issue a repeated START with the read bit. They then clock bytes out of the auto-incrementing slave. Writes go out in short bursts. After each burst the controller polls with read-address probes until the device acknowledges that its internal write is done. It then reads and discards one byte and moves to the next burst. A legacy mode handles older parts that take the offset in the address byte itself. Pages are not handled: a requester whose transfer may cross a page boundary must split the request itself. The end of each request is marked by a done pulse with an error flag.

Top module: `i2c_blk_xfer`

## Requirements
- R1: A request with length 0 is accepted and gives done with no error in the next cycle. It issues no engine command.
- R2: In normal mode a read issues the following, in order: WRITE with start and byte {dev,0}, WRITE of the offset byte, GAP, then WRITE with start and byte {dev,1}. The engine opcodes are WRITE=0, READ=1, STOP=2 and GAP=3. An address byte carries the device in bits 7:1 and the R/W bit in bit 0, where 1 means read.
- R3: In legacy mode the single address byte is {offset[6:0], R/W}, sent as WRITE with start. No offset byte and no GAP follow it.
- R4: A read of N bytes issues N READ commands, then STOP. Every READ carries ack=1 except the last, which carries ack=0. Each returned byte is offered on the read port, in order.
- R5: When the engine reports a NACK (rsp_nack=1) on any addressing byte, the controller issues STOP and ends the request with an error.
- R6: Writes go out in bursts of at most BURST data bytes, 4 by default. Each burst is addressed again from the start, using an offset advanced by the bytes already sent, modulo 256.
- R7: Each write burst ends with STOP. The controller then issues poll probes: WRITE with start and byte {dev,1}, or {offset[6:0],1} in legacy mode, where the offset is the next one. A STOP follows every probe that is NACKed.
- R8: After POLL_MAX probes in a row are NACKed, the request ends with an error once the STOP that follows the last probe is done.
- R9: Once a probe is acknowledged, the controller issues one READ with ack=0 and then STOP. The byte from that READ never appears on the read port.
- R10: A NACK on a write data byte causes a STOP, and the request ends with an error.
- R11: Only one engine command is outstanding at a time. An offered command stays unchanged until it is accepted. A write byte is taken only in the cycle its WRITE command is accepted.
- R12: done is a one-cycle pulse, and error is valid only while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, takes the request |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_legacy | input | 1 | 1 = offset travels in the address byte |
| req_dev | input | 7 | Device address |
| req_offset | input | 8 | Starting register offset |
| req_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Engine command offered |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | Opcode: 0 WRITE, 1 READ, 2 STOP, 3 GAP |
| cmd_start | output | 1 | Put a START before the WRITE byte |
| cmd_ack | output | 1 | On READ: 1 = acknowledge the byte |
| cmd_data | output | 8 | Byte for WRITE |
| rsp_valid | input | 1 | Engine finished the outstanding command |
| rsp_nack | input | 1 | On WRITE: the slave did not acknowledge |
| rsp_data | input | 8 | On READ: byte received |
| xfer_done | output | 1 | Request finished (pulse) |
| xfer_err | output | 1 | Request failed, valid with xfer_done |

## Verification
The bench samples every port 1 ns after the falling edge. A command offered there with cmd_ready high is accepted at the next rising edge. Its response is driven two falling edges later, so the controller sees it one rising edge after that. The next command or read byte appears from the state registered at that edge. xfer_done is due one cycle after the response to the closing STOP is consumed, or one cycle after a zero-length request is accepted. The bench therefore compares each command in acceptance order against a trace built from the requirements, without counting cycles, and checks done, error, read bytes and write-byte consumption once the pulse has been seen.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_STOP  = 2'd2,
    OP_GAP   = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_OFFS,
    S_GAP,
    S_RADDR,
    S_RDATA,
    S_RPUSH,
    S_WDATA,
    S_WSTOP,
    S_POLL,
    S_PSTOP,
    S_PREAD,
    S_DSTOP,
    S_FSTOP,
    S_DONE
  } state_e;

endpackage

// File: rtl/i2c_blk_track.sv
module i2c_blk_track #(
  parameter int LEN_W = 8,
  parameter int BURST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       load_off,
  input  logic [LEN_W-1:0] load_len,
  input  logic             burst_load,
  input  logic             step,
  input  logic             adv_off,
  output logic [7:0]       off,
  output logic             rem_zero,
  output logic             rem_one,
  output logic             burst_last
);

  localparam int BCW = $clog2(BURST + 1);

  logic [LEN_W-1:0] rem, rem_n;
  logic [BCW-1:0]   bcnt, bcnt_n;
  logic [7:0]       off_n;

  always_comb begin
    rem_n  = rem;
    bcnt_n = bcnt;
    off_n  = off;
    if (load) begin
      rem_n  = load_len;
      off_n  = load_off;
      bcnt_n = '0;
    end else begin
      if (burst_load)
        bcnt_n = (rem < LEN_W'(BURST)) ? BCW'(rem) : BCW'(BURST);
      if (step) begin
        rem_n = rem - 1'b1;
        if (adv_off) begin
          bcnt_n = bcnt - 1'b1;
          off_n  = off + 8'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      bcnt <= '0;
      off  <= '0;
    end else begin
      rem  <= rem_n;
      bcnt <= bcnt_n;
      off  <= off_n;
    end
  end

  assign rem_zero   = (rem == '0);
  assign rem_one    = (rem == LEN_W'(1));
  assign burst_last = (bcnt == BCW'(1));

  // R6: a burst never holds more than BURST bytes
  p_burst_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BCW'(BURST));

  // R4: no byte is counted past the requested length
  p_no_underrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !rem_zero);

endmodule

// File: rtl/i2c_blk_poll.sv
module i2c_blk_poll #(
  parameter int POLL_MAX = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);

  localparam int PCW = $clog2(POLL_MAX + 1);

  logic [PCW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (clr)      cnt_n = '0;
    else if (inc) cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign hit = (cnt == PCW'(POLL_MAX - 1));

  // R8: failed probes never exceed the limit
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < PCW'(POLL_MAX));

  // R8: the sequencer stops counting once the last probe has failed
  p_no_inc_at_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !hit);

endmodule

// File: rtl/i2c_blk_xfer.sv
module i2c_blk_xfer
  import i2c_blk_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int BURST    = 4,
  parameter int POLL_MAX = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_legacy,
  input  logic [6:0]       req_dev,
  input  logic [7:0]       req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic             cmd_start,
  output logic             cmd_ack,
  output logic [7:0]       cmd_data,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  input  logic [7:0]       rsp_data,
  output logic             xfer_done,
  output logic             xfer_err
);

  logic [1:0] rst_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  state_e     state, state_n;
  logic       busy, busy_n, err_r, err_n;
  logic       wr_mode, lg_mode;
  logic [6:0] dev_r;
  logic [7:0] rd_buf;
  logic       req_take, trk_load, burst_load, step, poll_clr, poll_inc, rd_cap;
  logic [7:0] off;
  logic       rem_zero, rem_one, burst_last, poll_hit;
  logic       has_cmd, cmd_issue;
  op_e        op_q;

  i2c_blk_track #(.LEN_W(LEN_W), .BURST(BURST)) u_track (
    .clk(clk), .rst_n(rst_s_n), .load(trk_load), .load_off(req_offset),
    .load_len(req_len), .burst_load(burst_load), .step(step), .adv_off(wr_mode),
    .off(off), .rem_zero(rem_zero), .rem_one(rem_one), .burst_last(burst_last)
  );

  i2c_blk_poll #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_s_n), .clr(poll_clr), .inc(poll_inc), .hit(poll_hit)
  );

  // command presented in each state
  always_comb begin
    has_cmd   = 1'b1;
    op_q      = OP_STOP;
    cmd_start = 1'b0;
    cmd_ack   = 1'b0;
    cmd_data  = 8'h00;
    case (state)
      S_ADDR: begin
        op_q      = OP_WRITE;
        cmd_start = 1'b1;
        cmd_data  = lg_mode ? {off[6:0], ~wr_mode} : {dev_r, 1'b0};
      end
      S_OFFS:  begin op_q = OP_WRITE; cmd_data = off; end
      S_GAP:   op_q = OP_GAP;
      S_RADDR: begin op_q = OP_WRITE; cmd_start = 1'b1; cmd_data = {dev_r, 1'b1}; end
      S_RDATA: begin op_q = OP_READ; cmd_ack = !rem_one; end
      S_WDATA: begin op_q = OP_WRITE; cmd_data = wr_data; end
      S_POLL: begin
        op_q      = OP_WRITE;
        cmd_start = 1'b1;
        cmd_data  = lg_mode ? {off[6:0], 1'b1} : {dev_r, 1'b1};
      end
      S_PREAD: op_q = OP_READ;
      S_WSTOP, S_PSTOP, S_DSTOP, S_FSTOP: op_q = OP_STOP;
      default: has_cmd = 1'b0;
    endcase
  end

  assign cmd_op    = op_q;
  assign cmd_valid = has_cmd && !busy && ((state != S_WDATA) || wr_valid);
  assign cmd_issue = cmd_valid && cmd_ready;
  assign wr_ready  = (state == S_WDATA) && !busy && cmd_ready;
  assign req_ready = (state == S_IDLE);
  assign req_take  = req_ready && req_valid;
  assign rd_valid  = (state == S_RPUSH);
  assign rd_data   = rd_buf;
  assign xfer_done = (state == S_DONE);
  assign xfer_err  = xfer_done && err_r;

  // next-state logic
  always_comb begin
    state_n    = state;
    busy_n     = busy;
    err_n      = err_r;
    trk_load   = 1'b0;
    burst_load = 1'b0;
    step       = 1'b0;
    poll_clr   = 1'b0;
    poll_inc   = 1'b0;
    rd_cap     = 1'b0;
    if (cmd_issue) busy_n = 1'b1;
    if (rsp_valid) busy_n = 1'b0;
    case (state)
      S_IDLE: if (req_valid) begin
        trk_load = 1'b1;
        err_n    = 1'b0;
        state_n  = (req_len == '0) ? S_DONE : S_ADDR;
      end
      S_ADDR: begin
        if (cmd_issue && wr_mode) burst_load = 1'b1;
        if (rsp_valid) begin
          if (rsp_nack) begin err_n = 1'b1; state_n = S_FSTOP; end
          else if (lg_mode) state_n = wr_mode ? S_WDATA : S_RDATA;
          else state_n = S_OFFS;
        end
      end
      S_OFFS: if (rsp_valid) begin
        if (rsp_nack) begin err_n = 1'b1; state_n = S_FSTOP; end
        else state_n = wr_mode ? S_WDATA : S_GAP;
      end
      S_GAP: if (rsp_valid) state_n = S_RADDR;
      S_RADDR: if (rsp_valid) begin
        if (rsp_nack) begin err_n = 1'b1; state_n = S_FSTOP; end
        else state_n = S_RDATA;
      end
      S_RDATA: if (rsp_valid) begin
        rd_cap  = 1'b1;
        step    = 1'b1;
        state_n = S_RPUSH;
      end
      S_RPUSH: if (rd_ready) state_n = rem_zero ? S_FSTOP : S_RDATA;
      S_WDATA: if (rsp_valid) begin
        if (rsp_nack) begin err_n = 1'b1; state_n = S_FSTOP; end
        else begin
          step    = 1'b1;
          state_n = burst_last ? S_WSTOP : S_WDATA;
        end
      end
      S_WSTOP: if (rsp_valid) begin poll_clr = 1'b1; state_n = S_POLL; end
      S_POLL: if (rsp_valid) begin
        if (rsp_nack) begin
          if (poll_hit) err_n = 1'b1;
          else          poll_inc = 1'b1;
          state_n = S_PSTOP;
        end else state_n = S_PREAD;
      end
      S_PSTOP: if (rsp_valid) state_n = err_r ? S_DONE : S_POLL;
      S_PREAD: if (rsp_valid) state_n = S_DSTOP;
      S_DSTOP: if (rsp_valid) state_n = rem_zero ? S_DONE : S_ADDR;
      S_FSTOP: if (rsp_valid) state_n = S_DONE;
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state <= S_IDLE;
      busy  <= 1'b0;
      err_r <= 1'b0;
    end else begin
      state <= state_n;
      busy  <= busy_n;
      err_r <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wr_mode <= 1'b0;
      lg_mode <= 1'b0;
      dev_r   <= '0;
    end else if (req_take) begin
      wr_mode <= req_write;
      lg_mode <= req_legacy;
      dev_r   <= req_dev;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    rd_buf <= '0;
    else if (rd_cap) rd_buf <= rsp_data;
  end

  // R11: the engine answers only while nothing new is offered
  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |-> !cmd_valid);

  // R11: a stalled command is held
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_start));

  // R11: write bytes are consumed only with an accepted WRITE
  p_wr_take_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_ready && wr_valid |-> cmd_ready && cmd_op == OP_WRITE);

  // R1: empty request finishes at once without error
  p_zero_len_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_valid && req_ready && req_len == '0 |=> xfer_done && !xfer_err);

  // R12: done lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    xfer_done |=> !xfer_done);

endmodule

// File: tb/i2c_blk_xfer_bench.sv
`timescale 1ns/1ps
module i2c_blk_xfer_bench;

  localparam int B = 4;
  localparam int P = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       req_valid, req_ready, req_write, req_legacy;
  logic [6:0] req_dev;
  logic [7:0] req_offset, req_len;
  logic       wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic       rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic       cmd_valid, cmd_ready, cmd_start, cmd_ack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic       rsp_valid, rsp_nack;
  logic [7:0] rsp_data;
  logic       xfer_done, xfer_err;

  i2c_blk_xfer #(.LEN_W(8), .BURST(B), .POLL_MAX(P)) u_i2c_blk_xfer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_legacy(req_legacy), .req_dev(req_dev),
    .req_offset(req_offset), .req_len(req_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_start(cmd_start),
    .cmd_ack(cmd_ack), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_data(rsp_data), .xfer_done(xfer_done),
    .xfer_err(xfer_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // expected trace
  logic [1:0] e_op [256];
  bit         e_st [256];
  bit         e_ak [256];
  bit         e_nk [256];
  logic [7:0] e_dt [256];
  logic [7:0] e_rb [256];
  string      e_tag[256];
  int         e_n;
  logic [7:0] e_rd [64];
  int         e_rd_n;
  bit         e_err;
  int         e_wr_n;
  int         fail_at_g;

  function automatic logic [7:0] wdat(input int i);
    return 8'h3C + 8'(7 * i);
  endfunction

  task automatic put(input logic [1:0] op, input bit st, input bit ak,
                     input logic [7:0] dt, input logic [7:0] rb, input string tag,
                     input bit force_nk, output bit nk);
    nk = force_nk || (e_n == fail_at_g && op == 2'd0);
    if (e_n < 256) begin
      e_op[e_n] = op; e_st[e_n] = st; e_ak[e_n] = ak; e_nk[e_n] = nk;
      e_dt[e_n] = dt; e_rb[e_n] = rb; e_tag[e_n] = tag;
    end
    e_n++;
  endtask

  task automatic build(input bit wr, input bit lg, input logic [6:0] dev,
                       input logic [7:0] off, input int len, input int pfail);
    bit nk;
    logic [7:0] o;
    int rem;
    int w;
    e_n = 0; e_rd_n = 0; e_err = 0; e_wr_n = 0;
    if (len == 0) return;
    if (!wr) begin
      if (!lg) begin
        put(2'd0, 1, 0, {dev, 1'b0}, 8'h00, "R2", 0, nk);
        if (nk) begin put(2'd2, 0, 0, 0, 0, "R5", 0, nk); e_err = 1; return; end
        put(2'd0, 0, 0, off, 8'h00, "R2", 0, nk);
        if (nk) begin put(2'd2, 0, 0, 0, 0, "R5", 0, nk); e_err = 1; return; end
        put(2'd3, 0, 0, 0, 0, "R2", 0, nk);
        put(2'd0, 1, 0, {dev, 1'b1}, 8'h00, "R2", 0, nk);
        if (nk) begin put(2'd2, 0, 0, 0, 0, "R5", 0, nk); e_err = 1; return; end
      end else begin
        put(2'd0, 1, 0, {off[6:0], 1'b1}, 8'h00, "R3", 0, nk);
        if (nk) begin put(2'd2, 0, 0, 0, 0, "R5", 0, nk); e_err = 1; return; end
      end
      for (int k = 0; k < len; k++) begin
        e_rd[k] = 8'hA0 ^ 8'(off + 8'(k));
        put(2'd1, 0, k != len - 1, 0, e_rd[k], "R4", 0, nk);
      end
      e_rd_n = len;
      put(2'd2, 0, 0, 0, 0, "R4", 0, nk);
      return;
    end
    o = off; rem = len; w = 0;
    while (rem > 0) begin
      int b;
      if (lg) begin
        put(2'd0, 1, 0, {o[6:0], 1'b0}, 0, "R3", 0, nk);
        if (nk) begin put(2'd2, 0, 0, 0, 0, "R5", 0, nk); e_err = 1; e_wr_n = w; return; end
      end else begin
        put(2'd0, 1, 0, {dev, 1'b0}, 0, "R6", 0, nk);
        if (nk) begin put(2'd2, 0, 0, 0, 0, "R5", 0, nk); e_err = 1; e_wr_n = w; return; end
        put(2'd0, 0, 0, o, 0, "R6", 0, nk);
        if (nk) begin put(2'd2, 0, 0, 0, 0, "R5", 0, nk); e_err = 1; e_wr_n = w; return; end
      end
      b = (rem < B) ? rem : B;
      for (int i = 0; i < b; i++) begin
        put(2'd0, 0, 0, wdat(w), 0, "R6", 0, nk);
        w++;
        o = o + 8'd1;
        if (nk) begin put(2'd2, 0, 0, 0, 0, "R10", 0, nk); e_err = 1; e_wr_n = w; return; end
      end
      rem -= b;
      put(2'd2, 0, 0, 0, 0, "R7", 0, nk);
      for (int p = 0; p < P + 1; p++) begin
        put(2'd0, 1, 0, lg ? {o[6:0], 1'b1} : {dev, 1'b1}, 0, "R7", p < pfail, nk);
        if (!nk) break;
        if (p + 1 == P) begin
          put(2'd2, 0, 0, 0, 0, "R8", 0, nk);
          e_err = 1; e_wr_n = w; return;
        end
        put(2'd2, 0, 0, 0, 0, "R7", 0, nk);
      end
      put(2'd1, 0, 0, 0, 8'hEE, "R9", 0, nk);
      put(2'd2, 0, 0, 0, 0, "R9", 0, nk);
    end
    e_wr_n = w;
  endtask

  // engine and sink model
  int         got_n, cur, delay, wr_cnt, rd_n, done_n;
  bit         done_e;
  bit         stall_en;
  logic [7:0] rd_got [64];
  logic [7:0] lf = 8'h5B;

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    wr_data   = wdat(wr_cnt);
    lf        = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    cmd_ready = !stall_en || lf[0];
    if (delay > 0) begin
      delay--;
      if (delay == 0) begin
        rsp_valid = 1'b1;
        rsp_nack  = e_nk[cur];
        rsp_data  = e_rb[cur];
      end
    end
    #1;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (got_n < e_n) begin
        bit ok;
        ok = (cmd_op == e_op[got_n]) &&
             (cmd_op != 2'd0 || (cmd_start == e_st[got_n] && cmd_data == e_dt[got_n])) &&
             (cmd_op != 2'd1 || cmd_ack == e_ak[got_n]);
        chk(ok, e_tag[got_n], "command",
            int'({cmd_op, cmd_start, cmd_ack, cmd_data}),
            int'({e_op[got_n], e_st[got_n], e_ak[got_n], e_dt[got_n]}));
        cur = got_n;
      end else begin
        chk(0, "R11", "extra command", got_n, e_n);
        cur = 0;
      end
      got_n++;
      delay = 2;
    end
    if (rst_n && wr_valid && wr_ready) wr_cnt++;
    if (rst_n && rd_valid && rd_ready) begin
      if (rd_n < 64) rd_got[rd_n] = rd_data;
      rd_n++;
    end
    if (rst_n && xfer_done) begin
      done_n++;
      done_e = xfer_err;
    end
  end

  task automatic run_case(input bit wr, input bit lg, input logic [6:0] dev,
                          input logic [7:0] off, input int len, input int fa,
                          input int pfail, input bit stall, input string tag);
    fail_at_g = fa;
    build(wr, lg, dev, off, len, pfail);
    @(negedge clk);
    #2;
    got_n = 0; wr_cnt = 0; rd_n = 0; done_n = 0; delay = 0; stall_en = stall;
    req_write = wr; req_legacy = lg; req_dev = dev; req_offset = off;
    req_len = 8'(len);
    chk(req_ready == 1'b1, tag, "idle before request", int'(req_ready), 1);
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int t = 0; t < 4000 && done_n == 0; t++) @(negedge clk);
    repeat (5) @(negedge clk);
    #2;
    chk(done_n == 1, "R12", "done pulses", done_n, 1);
    chk(done_e == e_err, e_err ? "R5" : tag, "error flag", int'(done_e), int'(e_err));
    chk(got_n == e_n, tag, "command count", got_n, e_n);
    chk(wr_cnt == e_wr_n, "R11", "write bytes taken", wr_cnt, e_wr_n);
    chk(rd_n == e_rd_n, e_rd_n > 0 ? "R4" : "R9", "read bytes delivered", rd_n, e_rd_n);
    for (int k = 0; k < e_rd_n && k < rd_n; k++)
      chk(rd_got[k] == e_rd[k], "R4", "read byte", int'(rd_got[k]), int'(e_rd[k]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_legacy = 1'b0;
    req_dev = '0; req_offset = '0; req_len = '0;
    wr_valid = 1'b1; rd_ready = 1'b1;
    rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_data = '0; cmd_ready = 1'b1;
    got_n = 0; cur = 0; delay = 0; wr_cnt = 0; rd_n = 0; done_n = 0;
    done_e = 0; stall_en = 0; e_n = 0; fail_at_g = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R11", "reset cmd_valid", int'(cmd_valid), 0);
    chk(rd_valid == 1'b0, "R4", "reset rd_valid", int'(rd_valid), 0);
    chk(xfer_done == 1'b0, "R12", "reset done", int'(xfer_done), 0);

    // sweep: direction x mode x length, with offsets crossing 255 and polling retries
    for (int wr = 0; wr < 2; wr++)
      for (int lg = 0; lg < 2; lg++)
        for (int len = 0; len < 10; len++)
          run_case(bit'(wr), bit'(lg), 7'h50 ^ 7'(len), 8'hF8 + 8'(3 * len), len, -1,
                   len % 3, bit'(len & 1),
                   len == 0 ? "R1" : (wr != 0 ? "R6" : (lg != 0 ? "R3" : "R2")));

    // NACK injection at each early command position
    for (int lg = 0; lg < 2; lg++) begin
      for (int fa = 0; fa < 6; fa++)
        run_case(1'b1, bit'(lg), 7'h2A, 8'h10, 6, fa, 0, 1'b0, "R10");
      for (int fa = 0; fa < 4; fa++)
        run_case(1'b0, bit'(lg), 7'h2A, 8'h40, 3, fa, 0, 1'b1, "R5");
    end

    // polling: success on the last allowed probe, then exhaustion
    run_case(1'b1, 1'b0, 7'h33, 8'h00, 4, -1, P - 1, 1'b0, "R7");
    run_case(1'b1, 1'b0, 7'h33, 8'h00, 3, -1, P, 1'b1, "R8");
    run_case(1'b1, 1'b1, 7'h33, 8'h7E, 5, -1, P, 1'b0, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule